// File: doc/BRIEF.md
# Acknowledge-Polling Master Sequencer

After a master finishes loading data into a nonvolatile slave and closes the transfer with a stop, the slave runs an internal programming cycle. While that cycle runs, the slave does not acknowledge its address. This sequencer uses that behaviour to detect the end of the programming cycle. Each probe asks a byte-level bus engine to generate a start condition and then to send the slave address byte with the chosen direction bit. If the address byte is not acknowledged, the sequencer closes the probe with a stop and tries again. If it is acknowledged, the slave is ready.

On a successful probe the caller picks one of two endings. The sequencer can leave the transaction open, so the caller continues the normal read or write without a fresh start. Otherwise the sequencer closes the transaction with a stop. An optional probe limit ends the search with a timeout indication. Each completion reports how many probes were sent.

The bus engine sits outside this block. The sequencer talks to it through a request/completion handshake: `cmd_valid`, `cmd_op` and `cmd_data` go out, and `cmd_done` and `ack_rx` come back.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `bus_open` and `cmd_valid` are all 0.
- R2: Every probe is a START command followed by a WRITE_BYTE command. The byte carries `dev_addr` in bits 7:1 and `rd_dir` in bit 0 (1 = read).
- R3: When the WRITE_BYTE of a probe completes with `ack_rx` = 0, the next command is STOP. The command after that STOP is the START of a new probe.
- R4: When the address is acknowledged and `keep_open` was 1 at the request, no STOP is issued. `done` pulses with `bus_open` = 1.
- R5: When the address is acknowledged and `keep_open` was 0, one STOP is issued. `done` then pulses with `bus_open` = 0.
- R6: With `done`, `poll_count` equals the number of address bytes sent during the sequence.
- R7: If `max_polls` is nonzero and that many probes go unacknowledged, a final STOP is issued. `done` then pulses with `timeout` = 1 and `bus_open` = 0, even when `keep_open` is 1. A `max_polls` of 0 means there is no limit.
- R8: A `req` pulse while `busy` is 1 is ignored. It changes neither the address byte, the ending mode nor the probe limit of the running sequence.
- R9: `done` is a single-cycle pulse. It is registered on the clock edge that samples the final `cmd_done`, and `busy` is 0 in that cycle.
- R10: `cmd_valid` stays high, with `cmd_op` and `cmd_data` stable, until `cmd_done` is sampled. The opcodes are 0 = START, 1 = WRITE_BYTE and 2 = STOP.
- R11: In the cycle after an accepted `req`, `cmd_valid` is 1 with `cmd_op` = START. Polling begins with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a polling sequence (pulse) |
| dev_addr | input | 7 | Slave address |
| rd_dir | input | 1 | Direction bit placed in the probe byte |
| keep_open | input | 1 | 1: leave the transaction open after the acknowledge |
| max_polls | input | CNT_W | Probe limit, 0 = unlimited |
| cmd_valid | output | 1 | Command request to the bus engine |
| cmd_op | output | 2 | Command opcode |
| cmd_data | output | 8 | Byte for WRITE_BYTE |
| cmd_done | input | 1 | Engine completion pulse |
| ack_rx | input | 1 | Acknowledge seen, valid with `cmd_done` after WRITE_BYTE |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Probe limit reached, valid with `done` |
| bus_open | output | 1 | Transaction left open, valid with `done` |
| poll_count | output | CNT_W | Probes sent, valid from `done` until the next request |

## Verification
- **Start of polling:** the first START request is due one cycle after `req`. The bench samples it at the following falling edge.
- **Command handshake:** each later command appears one cycle after the engine model's `cmd_done` is sampled. The engine model logs every command at the falling edge on which it sees the request. It releases `cmd_done` only after a fixed latency, so the sequence of logged opcodes and bytes is exact.
- **Completion:** `done`, `timeout`, `bus_open` and `poll_count` are due in the cycle right after the final `cmd_done`. The bench waits for `done` at falling edges. It checks every result in that same cycle, and checks that `done` has fallen one cycle later.

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [6:0]       dev_addr,
  input  logic             rd_dir,
  input  logic             keep_open,
  input  logic [CNT_W-1:0] max_polls,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_data,
  input  logic             cmd_done,
  input  logic             ack_rx,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             bus_open,
  output logic [CNT_W-1:0] poll_count
);
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_STOP  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_ADDR, S_STOP} st_t;

  st_t              st;
  logic [7:0]       probe;
  logic             keep_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt;
  logic             fin;
  logic             tmo_q;

  wire [CNT_W-1:0] cnt_inc  = cnt + 1'b1;
  wire             at_limit = (lim_q != '0) && (cnt_inc == lim_q);

  assign busy       = (st != S_IDLE);
  assign cmd_valid  = busy;
  assign cmd_op     = (st == S_START) ? OP_START : (st == S_ADDR) ? OP_WRITE : OP_STOP;
  assign cmd_data   = (st == S_ADDR) ? probe : 8'h00;
  assign poll_count = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      probe    <= '0;
      keep_q   <= 1'b0;
      lim_q    <= '0;
      cnt      <= '0;
      fin      <= 1'b0;
      tmo_q    <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      bus_open <= 1'b0;
    end else begin
      done     <= 1'b0;
      timeout  <= 1'b0;
      bus_open <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          probe  <= {dev_addr, rd_dir};
          keep_q <= keep_open;
          lim_q  <= max_polls;
          cnt    <= '0;
          tmo_q  <= 1'b0;
          st     <= S_START;
        end
        S_START: if (cmd_done) st <= S_ADDR;
        S_ADDR: if (cmd_done) begin
          cnt <= cnt_inc;
          if (ack_rx && keep_q) begin
            done     <= 1'b1;
            bus_open <= 1'b1;
            st       <= S_IDLE;
          end else begin
            fin   <= ack_rx || at_limit;
            tmo_q <= !ack_rx && at_limit;
            st    <= S_STOP;
          end
        end
        S_STOP: if (cmd_done) begin
          if (fin) begin
            done    <= 1'b1;
            timeout <= tmo_q;
            st      <= S_IDLE;
          end else begin
            st <= S_START;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_hold_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));
  p_start_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (cmd_valid && cmd_op == OP_START));
  p_ignore_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |=> ($stable(probe) && $stable(keep_q) && $stable(lim_q)));
  p_tmo_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (done && !bus_open));
  p_open_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_open |-> done);
  p_count_lim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lim_q != '0) |-> (cnt <= lim_q));
endmodule

// File: tb/ack_poll_seq_tb.sv
module ack_poll_seq_tb;
  localparam int CNT_W = 8;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req, rd_dir, keep_open, cmd_done, ack_rx;
  logic [6:0] dev_addr;
  logic [CNT_W-1:0] max_polls;
  logic cmd_valid, busy, done, timeout, bus_open;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic [CNT_W-1:0] poll_count;

  ack_poll_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .dev_addr(dev_addr), .rd_dir(rd_dir),
    .keep_open(keep_open), .max_polls(max_polls), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_done(cmd_done), .ack_rx(ack_rx),
    .busy(busy), .done(done), .timeout(timeout), .bus_open(bus_open),
    .poll_count(poll_count));

  int n_chk = 0, n_bad = 0;
  int busy_n = 0, probes = 0, nlog = 0;
  int lop[64];
  int ldat[64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus engine model: slave stays busy for busy_n probes
  initial begin
    cmd_done = 1'b0;
    ack_rx   = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        if (nlog < 64) begin
          lop[nlog]  = int'(cmd_op);
          ldat[nlog] = int'(cmd_data);
        end
        nlog++;
        repeat (LAT) @(negedge clk);
        if (cmd_op == 2'd1) begin
          probes++;
          ack_rx = (probes > busy_n);
        end
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        ack_rx   = 1'b0;
      end
    end
  end

  // {busy, max, keep, dir, addr, exp_polls, exp_tmo, exp_open}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {8'd0, 8'd4, 1'b0, 1'b0, 7'h50, 8'd1, 1'b0, 1'b0},
    {8'd2, 8'd4, 1'b1, 1'b1, 7'h51, 8'd3, 1'b0, 1'b1},
    {8'd3, 8'd4, 1'b0, 1'b0, 7'h2A, 8'd4, 1'b0, 1'b0},
    {8'd5, 8'd4, 1'b1, 1'b0, 7'h7F, 8'd4, 1'b1, 1'b0},
    {8'd6, 8'd0, 1'b0, 1'b1, 7'h00, 8'd7, 1'b0, 1'b0},
    {8'd0, 8'd1, 1'b1, 1'b0, 7'h13, 8'd1, 1'b0, 1'b1}
  };

  task automatic run(input int bz, input int mx, input bit kp, input bit dr,
                     input int ad, input int ep, input bit et, input bit eo,
                     input bit inject);
    int wc;
    int k;
    int exp_len;
    @(negedge clk);
    busy_n = bz; probes = 0; nlog = 0;
    dev_addr = 7'(ad); rd_dir = dr; keep_open = kp; max_polls = CNT_W'(mx);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(cmd_valid && cmd_op == 2'd0, "R11 first START", int'(cmd_op), 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      dev_addr = 7'h66; rd_dir = ~dr; keep_open = ~kp; max_polls = 8'd1;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    wc = 0;
    while (!done && wc < 5000) begin
      @(negedge clk);
      wc++;
    end
    chk(wc < 5000, "R9 done seen", wc, 0);
    chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
    chk(int'(poll_count) == ep, "R6 poll_count", int'(poll_count), ep);
    chk(timeout == et, "R7 timeout", int'(timeout), int'(et));
    chk(bus_open == eo, eo ? "R4 bus_open" : "R5 bus_open", int'(bus_open), int'(eo));
    exp_len = ep * 3 - (eo ? 1 : 0);
    chk(nlog == exp_len, eo ? "R4 command count" : "R5 command count", nlog, exp_len);
    k = 0;
    for (int p = 0; p < ep; p++) begin
      if (k < 62 && k + 1 < nlog) begin
        chk(lop[k] == 0, "R2 START op", lop[k], 0);
        chk(lop[k+1] == 1, "R2 WRITE op", lop[k+1], 1);
        chk(ldat[k+1] == ((ad << 1) | int'(dr)), "R2 address byte", ldat[k+1], (ad << 1) | int'(dr));
        if (!(p == ep - 1 && eo) && k + 2 < nlog)
          chk(lop[k+2] == 2, "R3 STOP op", lop[k+2], 2);
      end
      k += 3;
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; dev_addr = '0; rd_dir = 1'b0; keep_open = 1'b0; max_polls = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !timeout && !bus_open && !cmd_valid, "R1 reset state",
        int'({busy, done, timeout, bus_open, cmd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid, "R1 idle after reset", int'(cmd_valid), 0);

    for (int v = 0; v < NV; v++) begin
      run(int'(VEC[v][34:27]), int'(VEC[v][26:19]), VEC[v][18], VEC[v][17],
          int'(VEC[v][16:10]), int'(VEC[v][9:2]), VEC[v][1], VEC[v][0], 1'b0);
    end

    // R8: request during a running sequence is ignored
    run(3, 0, 1'b0, 1'b0, 7'h11, 4, 1'b0, 1'b0, 1'b1);

    // R10: engine slow path keeps request stable until completion
    @(negedge clk);
    busy_n = 0; probes = 0; nlog = 0;
    dev_addr = 7'h05; rd_dir = 1'b1; keep_open = 1'b0; max_polls = 8'd2;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk(cmd_valid && cmd_op == 2'd0, "R10 START held", int'(cmd_op), 0);
    while (!done) @(negedge clk);
    chk(poll_count == 8'd1, "R6 single probe", int'(poll_count), 1);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule